// File: doc/BRIEF.md
# Burst Beat Address Sequencer

This block turns one burst request into the byte address of every beat of that burst. The request gives a start address, a beat count (stored as count minus one), a beat size as a power-of-two byte count and a two-bit burst kind. After that single request, the block works out every later address itself. It moves one beat forward each time the surrounding logic strobes `advance`, and it raises `last` while the final beat is presented.

It sits between the address-channel handshake and the data-channel beats of a memory-mapped slave or a DMA engine. The owner pulses `load` when an address request is accepted. It pulses `advance` each time a data beat is exchanged, and it uses `addr` and `last` to address storage and to mark the closing beat. Three burst kinds are supported:

- **Fixed:** the address stays put.
- **Incrementing:** the address rises by the beat size on each beat.
- **Wrapping:** the address rises inside an aligned window and folds back to the window base when it passes the top.

Top module: `burst_addr_gen`

## Requirements
- R1: One cycle after `load` is sampled high, `addr` equals the sampled `start_addr`, `busy` is 1 and `last` is 1 exactly when `beat_len` was 0.
- R2: With `burst_kind` = 2'b00 (fixed), every beat of the burst presents the start address.
- R3: With `burst_kind` = 2'b01 (incrementing), each accepted `advance` raises `addr` by 2^`beat_size` bytes.
- R4: With `burst_kind` = 2'b10 (wrapping), the window is (`beat_len`+1)·2^`beat_size` bytes and its base is the start address rounded down to a multiple of the window. Addresses rise by 2^`beat_size` and fold back to the base on passing the window top. Wrapping is defined for 2, 4, 8 or 16 beats.
- R5: The code 2'b11 on `burst_kind` behaves exactly like incrementing.
- R6: `last` is 1 on beat number `beat_len`+1 (counting from 1) and 0 on every earlier beat.
- R7: An `advance` while `last` is 1 clears `busy` and `last` on the next cycle and leaves `addr` unchanged.
- R8: When `load` and `advance` are high together, the load wins: the new burst starts from its first beat and no step of the old burst occurs.
- R9: While `busy` is 0, `advance` has no effect: `addr` holds and `busy` stays 0.
- R10: After synchronous reset, `addr` is 0 and `busy` and `last` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Start a new burst with the request fields below |
| start_addr | input | ADDR_W | Byte address of the first beat |
| beat_len | input | LEN_W | Number of beats minus one |
| beat_size | input | 3 | Log2 of bytes per beat |
| burst_kind | input | 2 | 00 fixed, 01 incrementing, 10 wrapping, 11 treated as incrementing |
| advance | input | 1 | Current beat consumed; move to the next |
| addr | output | ADDR_W | Byte address of the current beat |
| last | output | 1 | Current beat is the final one of the burst |
| busy | output | 1 | A burst is in progress |

## Verification
The bench starts wrapping bursts in the middle of their window, at both byte and word granularity. A sequencer that wraps on the wrong edge, or that derives the base from the wrong window size, produces addresses outside the window or in the wrong order. It runs single-beat bursts, where a counter that is off by one would never raise `last` or would raise it a beat late. It keeps strobing `advance` after a burst ends, which catches a design that carries on stepping `addr`. It collides `load` with `advance` mid-burst, where a design with the wrong priority would present a stepped old address instead of the new start. Reserved-kind and fixed bursts confirm that the kind decode neither freezes nor steps by mistake.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    localparam int SIZE_W = 3;

    typedef enum logic [1:0] {
        BK_FIXED = 2'b00,
        BK_INCR  = 2'b01,
        BK_WRAP  = 2'b10,
        BK_RSVD  = 2'b11
    } burst_kind_e;

    typedef struct packed {
        burst_kind_e         kind;
        logic [SIZE_W-1:0]   size;
    } burst_cfg_t;

    // byte mask of one wrap window: (beats * bytes per beat) - 1
    function automatic logic [63:0] span_mask(input logic [15:0] len_m1,
                                              input logic [SIZE_W-1:0] size);
        return ((64'(len_m1) + 64'd1) << size) - 64'd1;
    endfunction

    function automatic logic [63:0] step_addr(input logic [63:0] cur,
                                              input burst_cfg_t cfg,
                                              input logic [63:0] mask);
        logic [63:0] inc;
        logic [63:0] nxt;
        inc = 64'd1 << cfg.size;
        case (cfg.kind)
            BK_FIXED: nxt = cur;
            BK_WRAP:  nxt = (cur & ~mask) | ((cur + inc) & mask);
            default:  nxt = cur + inc;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/beat_tracker.sv
module beat_tracker #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] len_m1,
    input  logic             step,
    output logic             busy,
    output logic             last
);
    logic [LEN_W-1:0] remain_q;
    logic             busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            remain_q <= '0;
        end else if (load) begin
            busy_q   <= 1'b1;
            remain_q <= len_m1;
        end else if (step && busy_q) begin
            if (remain_q == '0) busy_q <= 1'b0;
            else                remain_q <= remain_q - 1'b1;
        end
    end

    assign busy = busy_q;
    assign last = busy_q && (remain_q == '0);

    AST_LAST_CLEARS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (last && step && !load) |=> (!busy && !last)); // R7
    AST_IDLE_STAYS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!busy && !load) |=> !busy); // R9
endmodule

// File: rtl/addr_stepper.sv
module addr_stepper
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic [SIZE_W-1:0] size,
    input  logic [1:0]        kind,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] mask_q;
    burst_cfg_t        cfg_q;
    logic [ADDR_W-1:0] addr_nxt;

    assign addr_nxt = ADDR_W'(step_addr(64'(addr_q), cfg_q, 64'(mask_q)));

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            mask_q <= '0;
            cfg_q  <= '{kind: BK_INCR, size: '0};
        end else if (load) begin
            addr_q <= start_addr;
            mask_q <= ADDR_W'(span_mask(16'(len_m1), size));
            cfg_q  <= '{kind: burst_kind_e'(kind), size: size};
        end else if (step) begin
            addr_q <= addr_nxt;
        end
    end

    assign addr = addr_q;

    AST_FIXED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (step && !load && cfg_q.kind == BK_FIXED) |=> $stable(addr_q)); // R2
    AST_INCR_STEPS: assert property (@(posedge clk) disable iff (rst)
        (step && !load && (cfg_q.kind == BK_INCR || cfg_q.kind == BK_RSVD))
        |=> (addr_q == $past(addr_q) + (ADDR_W'(1) << $past(cfg_q.size)))); // R3
    AST_WRAP_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (step && !load && cfg_q.kind == BK_WRAP)
        |=> ((addr_q & ~mask_q) == ($past(addr_q) & ~$past(mask_q)))); // R4
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  beat_len,
    input  logic [SIZE_W-1:0] beat_size,
    input  logic [1:0]        burst_kind,
    input  logic              advance,
    output logic [ADDR_W-1:0] addr,
    output logic              last,
    output logic              busy
);
    logic beat_step;
    logic addr_step;

    // load outranks advance; a step past the final beat only ends the burst
    assign beat_step = advance && busy && !load;
    assign addr_step = beat_step && !last;

    beat_tracker #(.LEN_W(LEN_W)) u_track (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .len_m1 (beat_len),
        .step   (beat_step),
        .busy   (busy),
        .last   (last)
    );

    addr_stepper #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_step (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .start_addr (start_addr),
        .len_m1     (beat_len),
        .size       (beat_size),
        .kind       (burst_kind),
        .step       (addr_step),
        .addr       (addr)
    );

    AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (rst)
        load |=> (busy && addr == $past(start_addr)
                  && last == ($past(beat_len) == '0))); // R1
    AST_LOAD_BEATS_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (load && advance) |=> (addr == $past(start_addr))); // R8
    AST_IDLE_ADDR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!busy && !load) |=> $stable(addr)); // R9
    AST_LAST_ADDR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (last && advance && !load) |=> $stable(addr)); // R7
endmodule

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          load = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [7:0]    beat_len = '0;
    logic [2:0]    beat_size = '0;
    logic [1:0]    burst_kind = '0;
    logic          advance = 1'b0;
    logic [AW-1:0] addr;
    logic          last;
    logic          busy;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    burst_addr_gen u_burst_addr_gen (
        .clk(clk), .rst(rst), .load(load), .start_addr(start_addr),
        .beat_len(beat_len), .beat_size(beat_size), .burst_kind(burst_kind),
        .advance(advance), .addr(addr), .last(last), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // independent reference for beat i of a burst
    function automatic logic [AW-1:0] model(input logic [AW-1:0] st, input int len,
                                            input int sz, input logic [1:0] kd, input int i);
        longint bytes, win, base;
        bytes = longint'(1) << sz;
        if (kd == 2'b00) return st;
        if (kd == 2'b10) begin
            win  = (len + 1) * bytes;
            base = longint'(st) - (longint'(st) % win);
            return AW'(base + ((longint'(st) - base + i * bytes) % win));
        end
        return AW'(longint'(st) + i * bytes);
    endfunction

    task automatic do_load(input logic [AW-1:0] st, input int len, input int sz,
                           input logic [1:0] kd, input bit with_adv);
        @(negedge clk);
        load = 1'b1; advance = with_adv;
        start_addr = st; beat_len = 8'(len); beat_size = 3'(sz); burst_kind = kd;
        @(negedge clk);
        load = 1'b0; advance = 1'b0;
    endtask

    task automatic step_once();
        advance = 1'b1;
        @(negedge clk);
        advance = 1'b0;
    endtask

    task automatic run_burst(input string req, input logic [AW-1:0] st, input int len,
                             input int sz, input logic [1:0] kd);
        logic [AW-1:0] e;
        do_load(st, len, sz, kd, 1'b0);
        for (int i = 0; i <= len; i++) begin
            e = model(st, len, sz, kd, i);
            chk(addr == e, req, addr, e);
            chk(last == (i == len), "R6 last flag", last, (i == len));
            chk(busy == 1'b1, "R1 busy during burst", busy, 1);
            step_once();
        end
        chk(!busy && !last, "R7 burst end", {busy, last}, 0);
        chk(addr == model(st, len, sz, kd, len), "R7 addr held at end", addr,
            model(st, len, sz, kd, len));
    endtask

    task automatic test_reset();
        chk(addr == '0, "R10 reset addr", addr, 0);
        chk(!busy && !last, "R10 reset flags", {busy, last}, 0);
    endtask

    task automatic test_single_beat();
        do_load(32'h0000_0A00, 0, 2, 2'b01, 1'b0);
        chk(last && busy, "R1 single beat last at load", {busy, last}, 3);
        chk(addr == 32'h0A00, "R1 single beat addr", addr, 32'h0A00);
        step_once();
        chk(!busy && addr == 32'h0A00, "R7 single beat done", {busy, addr}, 32'h0A00);
    endtask

    task automatic test_idle_ignore();
        logic [AW-1:0] held;
        held = addr;
        for (int k = 0; k < 3; k++) step_once();
        chk(addr == held, "R9 idle advance addr", addr, held);
        chk(!busy && !last, "R9 idle advance flags", {busy, last}, 0);
    endtask

    task automatic test_load_priority();
        do_load(32'h0000_0500, 3, 2, 2'b01, 1'b0);
        step_once();
        chk(addr == 32'h0504, "R3 before collision", addr, 32'h0504);
        do_load(32'h0000_0800, 1, 2, 2'b01, 1'b1);
        chk(addr == 32'h0800, "R8 load wins addr", addr, 32'h0800);
        chk(busy && !last, "R8 load wins counter", {busy, last}, 2);
        step_once();
        chk(addr == 32'h0804 && last, "R8 new burst steps", addr, 32'h0804);
        step_once();
        chk(!busy, "R8 new burst ends", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        run_burst("R3 incr word",   32'h0000_0100, 3, 2, 2'b01);
        run_burst("R2 fixed",       32'h0000_0040, 2, 3, 2'b00);
        run_burst("R4 wrap 4x4",    32'h0000_0038, 3, 2, 2'b10);
        run_burst("R4 wrap 8x1",    32'h0000_1005, 7, 0, 2'b10);
        run_burst("R4 wrap 16x8",   32'h0000_2068, 15, 3, 2'b10);
        run_burst("R4 wrap 2x2",    32'h0000_0302, 1, 1, 2'b10);
        run_burst("R5 reserved",    32'h0000_0200, 2, 1, 2'b11);
        test_idle_ignore();
        test_single_beat();
        test_load_priority();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule